// File: doc/BRIEF.md
# Dead-Band Generator for a PWM Pair

This block sits between a PWM comparator stage and the output pins. It takes a pair of PWM streams, A and B, and returns a pair with dead time inserted. It is typically used to drive the high and low switches of a half bridge, which must never conduct at the same time.

Two edge-delay units do the timing work. The rising-delay unit holds back the rising edges of the signal it is given. The falling-delay unit holds back the falling edges of its signal. Each unit picks A or B as its source, and each unit's result can be inverted. Each output can bypass its delay unit. A final swap stage can exchange the two outputs or make one output copy the other. All of these choices come from one packed configuration word.

The delays are unsigned counts of ticks. A tick is either every clock or a pulse on an external tick-enable input. Both outputs are registered, so a bypassed stream appears one clock after its input.

Top module: `dtg_deadband`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, both outputs are 0.
- R2: When `cfg_word[15]` is 1 and `cfg_word[9]` is 0, `pwm_a_o` equals `pwm_a_i` delayed by one clock. When `cfg_word[16]` is 1 and `cfg_word[10]` is 0, `pwm_b_o` equals `pwm_b_i` delayed by one clock. The value 0x18000 passes both streams straight through.
- R3: When `cfg_word[9]` and `cfg_word[10]` are both 1, the A-path result drives `pwm_b_o` and the B-path result drives `pwm_a_o`.
- R4: When only one of `cfg_word[9]` (A) or `cfg_word[10]` (B) is 1, that output copies the other path's result, and both outputs then show the same path.
- R5: The unbypassed A path carries the rising-delay unit. Its source is A when `cfg_word[11]` is 0 and B when it is 1. The unit's output goes high only after the source has been high for `rise_dly` ticks, and it falls in the same clock as the source. A high pulse shorter than the delay never appears.
- R6: The unbypassed B path carries the falling-delay unit. Its source is A when `cfg_word[12]` is 0 and B when it is 1. The unit's output goes high in the same clock as the source, and it falls only after the source has been low for `fall_dly` ticks.
- R7: `cfg_word[13]` inverts the rising-delay result and `cfg_word[14]` inverts the falling-delay result. Bypassed paths are not inverted.
- R8: With `cfg_word` = 0x04000, `pwm_a_o` and `pwm_b_o` are complementary copies of `pwm_a_i`, with dead time around each edge. The two outputs are never high at the same time.
- R9: When `cfg_word[17]` is 0, the delay counters advance on every clock. When it is 1, they advance only on clocks where `tick_en` is 1.
- R10: When `cfg_word[8]` is 1, the falling-delay unit takes the rising-delay unit's output before inversion, so the B path carries both delays. Inversion by `cfg_word[13]` does not reach this link.
- R11: A delay of 0 makes its unit pass the selected source unchanged, with the one-clock register latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 18 | Packed routing, inversion, bypass, swap and tick-source configuration |
| rise_dly | input | 16 | Rising-edge delay in ticks |
| fall_dly | input | 16 | Falling-edge delay in ticks |
| tick_en | input | 1 | External tick used when `cfg_word[17]` is 1 |
| pwm_a_i | input | 1 | Incoming PWM stream A |
| pwm_b_i | input | 1 | Incoming PWM stream B |
| pwm_a_o | output | 1 | Dead-banded output A |
| pwm_b_o | output | 1 | Dead-banded output B |

## Verification
Several behaviours are checked on every clock, because each can be judged from the ports and one cycle of history: straight pass-through under bypass, exchange under double swap, mutual exclusion of the outputs in the complementary mode, a freshly risen source never producing an output when the delay is nonzero, and counters holding when no tick arrives. Other behaviours depend on how long a level has been held, such as the exact cycle a delayed edge appears, the suppression of short pulses, the cascade in dual-edge mode and one-sided copying. Only the bench scenarios can show these, by comparing against a cycle model driven by random and directed patterns.

// File: rtl/dtg_pkg.sv
// Shared configuration layout of the dead-band generator.
// Assumes the configuration word is 18 bits wide, with the control fields in
// bits 17..8 at the positions firmware writes, and bits 7..0 unused.
package dtg_pkg;

    localparam int CFG_W = 18;

    typedef struct packed {
        logic       tick_sel;   // 17: 1 = count only on external tick
        logic       byp_b;      // 16: B output skips falling-delay unit
        logic       byp_a;      // 15: A output skips rising-delay unit
        logic       inv_fall;   // 14: invert falling-delay result
        logic       inv_rise;   // 13: invert rising-delay result
        logic       src_fall;   // 12: falling-delay source, 1 = B
        logic       src_rise;   // 11: rising-delay source, 1 = B
        logic       xch_b;      // 10: B output takes A path
        logic       xch_a;      //  9: A output takes B path
        logic       cascade;    //  8: falling unit fed by rising unit
        logic [7:0] spare;
    } dtg_cfg_t;

endpackage

// File: rtl/dtg_edge_delay.sv
// One edge-delay unit. It delays either the rising edges (RISE=1) or the
// falling edges (RISE=0) of sig_i by dly_i ticks. The opposite edge passes
// through in the same cycle.
// Assumes sig_i is synchronous to clk. A tick is any clock with adv_i high.
module dtg_edge_delay #(
    parameter int DLY_W = 16,
    parameter bit RISE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_i,
    input  logic             adv_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             sig_o
);
    // The counter starts saturated for a falling unit, so that no false
    // trailing pulse follows reset.
    localparam logic [DLY_W-1:0] CNT_INIT = RISE ? '0 : '1;

    logic             lvl;      // the level whose onset is being delayed
    logic [DLY_W-1:0] cnt_q;
    logic             act;

    assign lvl   = RISE ? sig_i : ~sig_i;
    assign act   = lvl && (cnt_q >= dly_i);
    assign sig_o = RISE ? act : ~act;

    // Count ticks while the delayed level is held, and clear when it drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_INIT;
        else if (!lvl)
            cnt_q <= '0;
        else if (adv_i && (cnt_q < dly_i))
            cnt_q <= cnt_q + 1'b1;
    end

    // R5 R6
    onset_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lvl && !$past(lvl) && (dly_i != '0)) |-> !act);

    // R9
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && !adv_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dtg_route.sv
// Output routing: a bypass choice per output, then the swap or copy stage.
// Purely combinational. The caller registers the result.
// Assumes the delay results are already inverted as configured.
module dtg_route (
    input  logic in_a,
    input  logic in_b,
    input  logic dly_a,
    input  logic dly_b,
    input  logic byp_a,
    input  logic byp_b,
    input  logic xch_a,
    input  logic xch_b,
    output logic out_a,
    output logic out_b
);
    logic path_a;
    logic path_b;

    // Pick the raw stream or the delay result for each path, then apply swap/copy.
    always_comb begin
        path_a = byp_a ? in_a : dly_a;
        path_b = byp_b ? in_b : dly_b;
        out_a  = xch_a ? path_b : path_a;
        out_b  = xch_b ? path_a : path_b;
    end

endmodule

// File: rtl/dtg_deadband.sv
// Dead-band generator for a PWM pair. Two edge-delay units feed a bypass and
// swap router, followed by one output register.
// Assumes all inputs are synchronous to clk.
module dtg_deadband
    import dtg_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic             tick_en,
    input  logic             pwm_a_i,
    input  logic             pwm_b_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o
);
    dtg_cfg_t cfg;
    logic     adv;
    logic     rise_src, fall_src;
    logic     rise_raw, fall_raw;
    logic     nxt_a, nxt_b;
    logic     unused_spare;

    assign cfg          = dtg_cfg_t'(cfg_word);
    assign unused_spare = ^cfg.spare;
    assign adv          = cfg.tick_sel ? tick_en : 1'b1;
    assign rise_src     = cfg.src_rise ? pwm_b_i : pwm_a_i;
    assign fall_src     = cfg.cascade ? rise_raw
                        : (cfg.src_fall ? pwm_b_i : pwm_a_i);

    dtg_edge_delay #(.DLY_W(DLY_W), .RISE(1'b1)) i_rise (
        .clk(clk), .rst_n(rst_n), .sig_i(rise_src), .adv_i(adv),
        .dly_i(rise_dly), .sig_o(rise_raw)
    );

    dtg_edge_delay #(.DLY_W(DLY_W), .RISE(1'b0)) i_fall (
        .clk(clk), .rst_n(rst_n), .sig_i(fall_src), .adv_i(adv),
        .dly_i(fall_dly), .sig_o(fall_raw)
    );

    dtg_route i_route (
        .in_a(pwm_a_i), .in_b(pwm_b_i),
        .dly_a(rise_raw ^ cfg.inv_rise), .dly_b(fall_raw ^ cfg.inv_fall),
        .byp_a(cfg.byp_a), .byp_b(cfg.byp_b),
        .xch_a(cfg.xch_a), .xch_b(cfg.xch_b),
        .out_a(nxt_a), .out_b(nxt_b)
    );

    // Register both outputs so the pins change only on clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_a_o <= 1'b0;
            pwm_b_o <= 1'b0;
        end else begin
            pwm_a_o <= nxt_a;
            pwm_b_o <= nxt_b;
        end
    end

    // R2
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_word[15] && !cfg_word[9])) |-> (pwm_a_o == $past(pwm_a_i)));

    // R2
    pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_word[16] && !cfg_word[10])) |-> (pwm_b_o == $past(pwm_b_i)));

    // R3
    exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_word[16:15] == 2'b11 && cfg_word[10:9] == 2'b11))
        |-> (pwm_a_o == $past(pwm_b_i) && pwm_b_o == $past(pwm_a_i)));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_word == 18'h04000)) |-> !(pwm_a_o && pwm_b_o));

endmodule

// File: tb/test_dtg_deadband.sv
module test_dtg_deadband;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] cfg_word = '0;
    logic [15:0] rise_dly = '0;
    logic [15:0] fall_dly = '0;
    logic        tick_en = 1'b0;
    logic        pwm_a_i = 1'b0;
    logic        pwm_b_i = 1'b0;
    logic        pwm_a_o, pwm_b_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dtg_deadband i_dtg_deadband (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .rise_dly(rise_dly),
        .fall_dly(fall_dly), .tick_en(tick_en), .pwm_a_i(pwm_a_i),
        .pwm_b_i(pwm_b_i), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o)
    );

    // Cycle model built from the requirements
    logic [15:0] m_rc, m_fc;
    logic        m_a, m_b;
    logic        s_adv, s_rin, s_rhi, s_fin, s_flo, s_fo, s_pa, s_pb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rc <= '0; m_fc <= '1; m_a <= 1'b0; m_b <= 1'b0;
        end else begin
            s_adv = cfg_word[17] ? tick_en : 1'b1;                  // R9
            s_rin = cfg_word[11] ? pwm_b_i : pwm_a_i;               // R5
            s_rhi = s_rin && (m_rc >= rise_dly);
            s_fin = cfg_word[8] ? s_rhi : (cfg_word[12] ? pwm_b_i : pwm_a_i); // R10 R6
            s_flo = !s_fin;
            s_fo  = !(s_flo && (m_fc >= fall_dly));
            s_pa  = cfg_word[15] ? pwm_a_i : (s_rhi ^ cfg_word[13]); // R7
            s_pb  = cfg_word[16] ? pwm_b_i : (s_fo ^ cfg_word[14]);
            m_a  <= cfg_word[9]  ? s_pb : s_pa;
            m_b  <= cfg_word[10] ? s_pa : s_pb;
            m_rc <= !s_rin ? 16'd0 : ((s_adv && m_rc < rise_dly) ? m_rc + 16'd1 : m_rc);
            m_fc <= !s_flo ? 16'd0 : ((s_adv && m_fc < fall_dly) ? m_fc + 16'd1 : m_fc);
        end
    end

    task automatic chk(input string tag);
        total++;
        if (pwm_a_o !== m_a || pwm_b_o !== m_b) begin
            bad++;
            $display("FAIL %s: actual a=%b b=%b expected a=%b b=%b", tag, pwm_a_o, pwm_b_o, m_a, m_b);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Compare each cycle, then drive new random inputs (toggle chance 1/togl).
    task automatic run(input int n, input int togl, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag);
            if ($urandom % togl == 0) pwm_a_i = ~pwm_a_i;
            if ($urandom % togl == 0) pwm_b_i = ~pwm_b_i;
            tick_en = ($urandom % 3 == 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        pwm_a_i = 1'b1; pwm_b_i = 1'b1; cfg_word = 18'h18000;
        repeat (3) @(negedge clk);
        chk_bit("R1 a in reset", pwm_a_o, 1'b0);
        chk_bit("R1 b in reset", pwm_b_o, 1'b0);
        pwm_a_i = 1'b0; pwm_b_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 a after reset", pwm_a_o, 1'b0);
        chk_bit("R1 b after reset", pwm_b_o, 1'b0);

        // R2 straight pass-through
        cfg_word = 18'h18000;
        run(60, 2, "R2");
        // R3 both swapped
        cfg_word = 18'h18600;
        run(60, 2, "R3");
        // R4 one-sided copy
        cfg_word = 18'h18200;
        run(40, 2, "R4 a copies b");
        cfg_word = 18'h18400;
        run(40, 2, "R4 b copies a");

        // R5 directed timing: rise delay 3, A path from A
        cfg_word = 18'h10000; rise_dly = 16'd3; fall_dly = 16'd0;
        pwm_a_i = 1'b0;
        repeat (5) @(negedge clk);
        pwm_a_i = 1'b1;
        repeat (3) @(negedge clk);
        chk_bit("R5 held low during delay", pwm_a_o, 1'b0);
        @(negedge clk);
        chk_bit("R5 rises after delay", pwm_a_o, 1'b1);
        pwm_a_i = 1'b0;
        @(negedge clk);
        chk_bit("R5 falls at once", pwm_a_o, 1'b0);
        // R5 short pulse suppressed
        rise_dly = 16'd5;
        pwm_a_i = 1'b1;
        repeat (3) @(negedge clk);
        pwm_a_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk_bit("R5 short pulse", pwm_a_o, 1'b0);
            @(negedge clk);
        end

        // R6 directed: fall delay 2 on B path from A
        cfg_word = 18'h08000; fall_dly = 16'd2;
        pwm_a_i = 1'b1;
        @(negedge clk);
        chk_bit("R6 rises at once", pwm_b_o, 1'b1);
        pwm_a_i = 1'b0;
        repeat (2) @(negedge clk);
        chk_bit("R6 held high", pwm_b_o, 1'b1);
        @(negedge clk);
        chk_bit("R6 falls after delay", pwm_b_o, 1'b0);

        // R5 R6 source selects, random
        rise_dly = 16'd4; fall_dly = 16'd3;
        cfg_word = 18'h01800;
        run(120, 6, "R5 R6 source B");
        cfg_word = 18'h00000;
        run(120, 6, "R5 R6 source A");
        // R7 inversion
        cfg_word = 18'h06000;
        run(120, 6, "R7");
        // R8 complementary mode
        cfg_word = 18'h04000; rise_dly = 16'd5; fall_dly = 16'd5;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            chk("R8");
            chk_bit("R8 no overlap", pwm_a_o & pwm_b_o, 1'b0);
            if ($urandom % 12 == 0) pwm_a_i = ~pwm_a_i;
        end
        // R9 external tick
        cfg_word = 18'h24000;
        run(300, 15, "R9");
        // R10 cascade
        cfg_word = 18'h02100; rise_dly = 16'd3; fall_dly = 16'd4;
        run(200, 8, "R10");
        // R11 zero delays
        cfg_word = 18'h00000; rise_dly = 16'd0; fall_dly = 16'd0;
        run(60, 2, "R11");

        // Mixed random configurations
        for (int r = 0; r < 40; r++) begin
            cfg_word = {$urandom % 1024, 8'h00};
            rise_dly = 16'($urandom % 8);
            fall_dly = 16'($urandom % 8);
            run(60, 5, "R7 R9 R10 mix");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule